// File: doc/BRIEF.md
# Fetch Redirect and Epoch Controller

This block sits at the front of an in-order pipeline and decides, every cycle, where instruction fetch goes next. It holds the fetch address, an instruction sequence counter and two small epoch tags. One tag follows redirects made by the execute stage. The other follows redirects made by the decode stage. Each cycle it picks one of three sources for the next address: the next-address predictor, a correction from execute, or a correction from decode.

Execute and decode push their corrections into two small internal queues. The controller drains at most one queue entry per cycle, and the execute queue always comes first. Every entry taken from the execute queue is passed on to the predictor as a training record. A correction that changes the fetch address costs one cycle in which nothing is fetched. A decode correction is obeyed only if it was made under the execute epoch that fetch currently holds. Otherwise it is discarded and fetch continues in the same cycle.

Each fetched instruction is pushed downstream as a bundle. The bundle holds the address, the instruction word, the sequence number, both epochs, the predictor's side information and the predicted next address. The instruction memory and the predictor both answer within the same cycle as the query.

Top module: `fetch_redirect_ctl`

## Requirements
- R1: After reset the fetch address is START_PC, the sequence number and both epochs are 0, and both feedback queues are empty (their full flags are low).
- R2: In a fetch cycle, imem_req_valid and fq_push are 1. The request address and fq_pc equal the fetch address. fq_inst is imem_rsp_data, fq_info is pred_info and fq_pred_next is pred_next. The epochs and sequence number are the current ones. Afterwards the fetch address becomes pred_next and the sequence number goes up by 1.
- R3: Whenever fetch is not stalled and the execute queue holds an entry, that entry is removed. trn_valid is 1 in that cycle, and trn_correct, trn_info and trn_addr carry the entry's fields.
- R4: An execute entry that marks a misprediction causes no fetch in its cycle. The execute epoch takes the entry's epoch, and the fetch address takes the entry's address.
- R5: An execute entry that marks a correct prediction still allows a normal fetch in the same cycle.
- R6: The decode queue is examined only in cycles where the execute queue is empty. Otherwise its head entry stays where it is.
- R7: A decode entry is obeyed only if its execute epoch equals the current execute epoch and it marks a misprediction. When obeyed, there is no fetch and no training in that cycle. The decode epoch takes the entry's decode epoch, and the fetch address takes the entry's address.
- R8: A decode entry with a mismatching execute epoch, or one marking a correct prediction, is removed. A normal fetch happens in the same cycle.
- R9: While fq_full is 1, nothing is fetched, nothing is trained, no queue entry is removed, and the fetch address, epochs and sequence number hold.
- R10: Each feedback queue holds FB_DEPTH entries in arrival order, and its full flag is high exactly when it holds FB_DEPTH entries. A push into a full queue is discarded, even if an entry leaves in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_req_valid | output | 1 | Instruction read issued this cycle |
| imem_req_addr | output | ADDR_W | Current fetch address |
| imem_rsp_data | input | INST_W | Instruction word for imem_req_addr, same cycle |
| pred_pc | output | ADDR_W | Address presented to the predictor |
| pred_next | input | ADDR_W | Predicted next fetch address |
| pred_info | input | INFO_W | Predictor side information for later training |
| trn_valid | output | 1 | Training record valid |
| trn_correct | output | 1 | Prediction was correct |
| trn_info | output | INFO_W | Side information returned to the predictor |
| trn_addr | output | ADDR_W | Actual next address |
| exe_fb_push | input | 1 | Execute feedback write |
| exe_fb_epoch | input | EP_W | New execute epoch carried by the feedback |
| exe_fb_correct | input | 1 | Execute found the prediction correct |
| exe_fb_info | input | INFO_W | Predictor side information |
| exe_fb_addr | input | ADDR_W | Actual next address |
| exe_fb_full | output | 1 | Execute feedback queue full |
| dec_fb_push | input | 1 | Decode feedback write |
| dec_fb_eepoch | input | EP_W | Execute epoch the decode feedback was made under |
| dec_fb_depoch | input | EP_W | New decode epoch |
| dec_fb_correct | input | 1 | Decode found the prediction correct |
| dec_fb_addr | input | ADDR_W | Corrected next address |
| dec_fb_full | output | 1 | Decode feedback queue full |
| fq_full | input | 1 | Downstream fetch queue cannot accept |
| fq_push | output | 1 | Fetch bundle valid |
| fq_pc | output | ADDR_W | Bundle address |
| fq_inst | output | INST_W | Bundle instruction word |
| fq_inum | output | INUM_W | Bundle sequence number |
| fq_eepoch | output | EP_W | Bundle execute epoch |
| fq_depoch | output | EP_W | Bundle decode epoch |
| fq_info | output | INFO_W | Bundle predictor side information |
| fq_pred_next | output | ADDR_W | Bundle predicted next address |

## Verification
The bench targets cycles in which both queues hold entries. A controller that let decode win, or drained both queues at once, would lose an execute redirect or skip training. It feeds decode entries whose execute epoch is stale. A design that obeyed them would jump fetch to a dead path and insert a bubble where none belongs. Long stretches of downstream back-pressure run while both queues are pushed past capacity. A wrong design would drop entries, reorder them, or advance fetch during the stall. Execute entries that mark a correct prediction are mixed in to catch a design that idles fetch or fails to train on them.

// File: rtl/fetch_redirect_pkg.sv
`timescale 1ns/1ps
package fetch_redirect_pkg;

  typedef enum logic [1:0] {
    ACT_FETCH     = 2'd0,
    ACT_STALL     = 2'd1,
    ACT_EXE_REDIR = 2'd2,
    ACT_DEC_REDIR = 2'd3
  } fetch_act_e;

  // A decode correction only counts on the live execute path and only if it
  // reports a wrong prediction.
  function automatic logic dec_obeyed(input logic same_eepoch, input logic correct);
    return same_eepoch && !correct;
  endfunction

endpackage

// File: rtl/fetch_fb_fifo.sv
`timescale 1ns/1ps
module fetch_fb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rp];

  always_ff @(posedge clk) begin
    if (do_push) store[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/fetch_arbiter.sv
`timescale 1ns/1ps
module fetch_arbiter
  import fetch_redirect_pkg::*;
#(
  parameter int EP_W = 2
) (
  input  logic            fq_full,
  input  logic            exe_avail,
  input  logic            exe_correct,
  input  logic            dec_avail,
  input  logic [EP_W-1:0] dec_eepoch,
  input  logic            dec_correct,
  input  logic [EP_W-1:0] cur_eepoch,
  output fetch_act_e      act,
  output logic            exe_pop,
  output logic            dec_pop,
  output logic            fetch_go
);
  always_comb begin
    act     = ACT_FETCH;
    exe_pop = 1'b0;
    dec_pop = 1'b0;
    if (fq_full) begin
      act = ACT_STALL;
    end else if (exe_avail) begin
      exe_pop = 1'b1;
      act     = exe_correct ? ACT_FETCH : ACT_EXE_REDIR;
    end else if (dec_avail) begin
      dec_pop = 1'b1;
      act     = dec_obeyed(dec_eepoch == cur_eepoch, dec_correct) ? ACT_DEC_REDIR : ACT_FETCH;
    end
  end

  assign fetch_go = (act == ACT_FETCH);
endmodule

// File: rtl/fetch_state.sv
`timescale 1ns/1ps
module fetch_state
  import fetch_redirect_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              EP_W     = 2,
  parameter int              INUM_W   = 16,
  parameter logic [ADDR_W-1:0] START_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fetch_act_e        act,
  input  logic [ADDR_W-1:0] pred_next,
  input  logic [EP_W-1:0]   exe_epoch,
  input  logic [ADDR_W-1:0] exe_addr,
  input  logic [EP_W-1:0]   dec_depoch,
  input  logic [ADDR_W-1:0] dec_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [EP_W-1:0]   eepoch,
  output logic [EP_W-1:0]   depoch,
  output logic [INUM_W-1:0] inum
);
  function automatic logic [INUM_W-1:0] inum_step(input logic [INUM_W-1:0] n);
    return n + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= START_PC;
      eepoch <= '0;
      depoch <= '0;
      inum   <= '0;
    end else begin
      unique case (act)
        ACT_FETCH: begin
          pc   <= pred_next;
          inum <= inum_step(inum);
        end
        ACT_EXE_REDIR: begin
          pc     <= exe_addr;
          eepoch <= exe_epoch;
        end
        ACT_DEC_REDIR: begin
          pc     <= dec_addr;
          depoch <= dec_depoch;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fetch_redirect_ctl.sv
`timescale 1ns/1ps
module fetch_redirect_ctl
  import fetch_redirect_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              INST_W   = 32,
  parameter int              INFO_W   = 32,
  parameter int              EP_W     = 2,
  parameter int              INUM_W   = 16,
  parameter int              FB_DEPTH = 2,
  parameter logic [ADDR_W-1:0] START_PC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              imem_req_valid,
  output logic [ADDR_W-1:0] imem_req_addr,
  input  logic [INST_W-1:0] imem_rsp_data,
  output logic [ADDR_W-1:0] pred_pc,
  input  logic [ADDR_W-1:0] pred_next,
  input  logic [INFO_W-1:0] pred_info,
  output logic              trn_valid,
  output logic              trn_correct,
  output logic [INFO_W-1:0] trn_info,
  output logic [ADDR_W-1:0] trn_addr,
  input  logic              exe_fb_push,
  input  logic [EP_W-1:0]   exe_fb_epoch,
  input  logic              exe_fb_correct,
  input  logic [INFO_W-1:0] exe_fb_info,
  input  logic [ADDR_W-1:0] exe_fb_addr,
  output logic              exe_fb_full,
  input  logic              dec_fb_push,
  input  logic [EP_W-1:0]   dec_fb_eepoch,
  input  logic [EP_W-1:0]   dec_fb_depoch,
  input  logic              dec_fb_correct,
  input  logic [ADDR_W-1:0] dec_fb_addr,
  output logic              dec_fb_full,
  input  logic              fq_full,
  output logic              fq_push,
  output logic [ADDR_W-1:0] fq_pc,
  output logic [INST_W-1:0] fq_inst,
  output logic [INUM_W-1:0] fq_inum,
  output logic [EP_W-1:0]   fq_eepoch,
  output logic [EP_W-1:0]   fq_depoch,
  output logic [INFO_W-1:0] fq_info,
  output logic [ADDR_W-1:0] fq_pred_next
);
  localparam int XW = EP_W + 1 + INFO_W + ADDR_W;
  localparam int DW = 2 * EP_W + 1 + ADDR_W;

  logic [XW-1:0]     exe_head;
  logic [DW-1:0]     dec_head;
  logic              exe_empty, dec_empty;
  logic              exe_pop, dec_pop, fetch_go;
  fetch_act_e        act;

  logic [EP_W-1:0]   exe_head_epoch;
  logic              exe_head_correct;
  logic [INFO_W-1:0] exe_head_info;
  logic [ADDR_W-1:0] exe_head_addr;
  logic [EP_W-1:0]   dec_head_eep, dec_head_dep;
  logic              dec_head_correct;
  logic [ADDR_W-1:0] dec_head_addr;

  logic [ADDR_W-1:0] cur_pc;
  logic [EP_W-1:0]   cur_eepoch, cur_depoch;
  logic [INUM_W-1:0] cur_inum;

  // named events for the checker
  logic ev_exe_redir, ev_dec_redir;

  fetch_fb_fifo #(.W(XW), .DEPTH(FB_DEPTH)) exe_q_i (
    .clk, .rst_n,
    .push      (exe_fb_push),
    .push_data ({exe_fb_epoch, exe_fb_correct, exe_fb_info, exe_fb_addr}),
    .pop       (exe_pop),
    .head      (exe_head),
    .empty     (exe_empty),
    .full      (exe_fb_full)
  );

  fetch_fb_fifo #(.W(DW), .DEPTH(FB_DEPTH)) dec_q_i (
    .clk, .rst_n,
    .push      (dec_fb_push),
    .push_data ({dec_fb_eepoch, dec_fb_depoch, dec_fb_correct, dec_fb_addr}),
    .pop       (dec_pop),
    .head      (dec_head),
    .empty     (dec_empty),
    .full      (dec_fb_full)
  );

  assign {exe_head_epoch, exe_head_correct, exe_head_info, exe_head_addr} = exe_head;
  assign {dec_head_eep, dec_head_dep, dec_head_correct, dec_head_addr}    = dec_head;

  fetch_arbiter #(.EP_W(EP_W)) arb_i (
    .fq_full     (fq_full),
    .exe_avail   (!exe_empty),
    .exe_correct (exe_head_correct),
    .dec_avail   (!dec_empty),
    .dec_eepoch  (dec_head_eep),
    .dec_correct (dec_head_correct),
    .cur_eepoch  (cur_eepoch),
    .act         (act),
    .exe_pop     (exe_pop),
    .dec_pop     (dec_pop),
    .fetch_go    (fetch_go)
  );

  fetch_state #(.ADDR_W(ADDR_W), .EP_W(EP_W), .INUM_W(INUM_W), .START_PC(START_PC)) st_i (
    .clk, .rst_n,
    .act        (act),
    .pred_next  (pred_next),
    .exe_epoch  (exe_head_epoch),
    .exe_addr   (exe_head_addr),
    .dec_depoch (dec_head_dep),
    .dec_addr   (dec_head_addr),
    .pc         (cur_pc),
    .eepoch     (cur_eepoch),
    .depoch     (cur_depoch),
    .inum       (cur_inum)
  );

  assign ev_exe_redir = (act == ACT_EXE_REDIR);
  assign ev_dec_redir = (act == ACT_DEC_REDIR);

  assign imem_req_valid = fetch_go;
  assign imem_req_addr  = cur_pc;
  assign pred_pc        = cur_pc;

  assign trn_valid   = exe_pop;
  assign trn_correct = exe_head_correct;
  assign trn_info    = exe_head_info;
  assign trn_addr    = exe_head_addr;

  assign fq_push      = fetch_go;
  assign fq_pc        = cur_pc;
  assign fq_inst      = imem_rsp_data;
  assign fq_inum      = cur_inum;
  assign fq_eepoch    = cur_eepoch;
  assign fq_depoch    = cur_depoch;
  assign fq_info      = pred_info;
  assign fq_pred_next = pred_next;
endmodule

// File: rtl/fetch_redirect_ctl_chk.sv
`timescale 1ns/1ps
module fetch_redirect_ctl_chk #(
  parameter int ADDR_W = 32,
  parameter int EP_W   = 2,
  parameter int INUM_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fq_full,
  input logic              fq_push,
  input logic              imem_req_valid,
  input logic [ADDR_W-1:0] imem_req_addr,
  input logic [ADDR_W-1:0] pred_next,
  input logic [INUM_W-1:0] fq_inum,
  input logic [EP_W-1:0]   fq_eepoch,
  input logic [EP_W-1:0]   fq_depoch,
  input logic              trn_valid,
  input logic              exe_pop,
  input logic              dec_pop,
  input logic              ev_exe_redir,
  input logic              ev_dec_redir,
  input logic [EP_W-1:0]   exe_head_epoch,
  input logic [ADDR_W-1:0] exe_head_addr,
  input logic [EP_W-1:0]   dec_head_dep,
  input logic [ADDR_W-1:0] dec_head_addr
);
  // R9
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fq_full |-> (!fq_push && !imem_req_valid && !trn_valid));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fq_full |=> ($stable(imem_req_addr) && $stable(fq_inum) && $stable(fq_eepoch) && $stable(fq_depoch)));

  // R2
  fetch_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fq_push |=> (imem_req_addr == $past(pred_next) && fq_inum == $past(fq_inum) + 1'b1));

  // R6
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exe_pop, dec_pop}));

  // R4
  exe_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exe_redir |-> (!fq_push && trn_valid));

  // R4
  exe_redir_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exe_redir |=> (imem_req_addr == $past(exe_head_addr) && fq_eepoch == $past(exe_head_epoch)));

  // R7
  dec_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dec_redir |-> (!fq_push && !trn_valid && dec_pop));

  // R7
  dec_redir_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dec_redir |=> (imem_req_addr == $past(dec_head_addr) && fq_depoch == $past(dec_head_dep)
                      && $stable(fq_eepoch)));
endmodule

bind fetch_redirect_ctl fetch_redirect_ctl_chk #(
  .ADDR_W(ADDR_W), .EP_W(EP_W), .INUM_W(INUM_W)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .fq_full        (fq_full),
  .fq_push        (fq_push),
  .imem_req_valid (imem_req_valid),
  .imem_req_addr  (imem_req_addr),
  .pred_next      (pred_next),
  .fq_inum        (fq_inum),
  .fq_eepoch      (fq_eepoch),
  .fq_depoch      (fq_depoch),
  .trn_valid      (trn_valid),
  .exe_pop        (exe_pop),
  .dec_pop        (dec_pop),
  .ev_exe_redir   (ev_exe_redir),
  .ev_dec_redir   (ev_dec_redir),
  .exe_head_epoch (exe_head_epoch),
  .exe_head_addr  (exe_head_addr),
  .dec_head_dep   (dec_head_dep),
  .dec_head_addr  (dec_head_addr)
);

// File: tb/fetch_redirect_ctl_tb_top.sv
`timescale 1ns/1ps
module fetch_redirect_ctl_tb_top;
  localparam int          D      = 2;
  localparam logic [31:0] START  = 32'h0000_1000;
  localparam logic [31:0] IKEY   = 32'hA5A5_0000;
  localparam int          NCYC   = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_req_valid;
  logic [31:0] imem_req_addr, imem_rsp_data, pred_pc, pred_next, pred_info;
  logic        trn_valid, trn_correct;
  logic [31:0] trn_info, trn_addr;
  logic        exe_fb_push = 1'b0, exe_fb_correct = 1'b0;
  logic [1:0]  exe_fb_epoch = '0;
  logic [31:0] exe_fb_info = '0, exe_fb_addr = '0;
  logic        exe_fb_full;
  logic        dec_fb_push = 1'b0, dec_fb_correct = 1'b0;
  logic [1:0]  dec_fb_eepoch = '0, dec_fb_depoch = '0;
  logic [31:0] dec_fb_addr = '0;
  logic        dec_fb_full;
  logic        fq_full = 1'b1;
  logic        fq_push;
  logic [31:0] fq_pc, fq_inst, fq_info, fq_pred_next;
  logic [15:0] fq_inum;
  logic [1:0]  fq_eepoch, fq_depoch;

  always #2.5 clk = ~clk;

  // environment: instruction memory and predictor answer in the same cycle
  function automatic logic [31:0] inst_of(input logic [31:0] a);
    return {a[15:0] ^ 16'h3c3c, ~a[15:0]};
  endfunction
  function automatic logic [31:0] guess_of(input logic [31:0] a);
    if (a[5:2] == 4'd7) return a + 32'h40;
    return a + 32'd4;
  endfunction
  assign imem_rsp_data = inst_of(imem_req_addr);
  assign pred_next     = guess_of(pred_pc);
  assign pred_info     = pred_pc ^ IKEY;

  fetch_redirect_ctl dut_i (
    .clk, .rst_n, .imem_req_valid, .imem_req_addr, .imem_rsp_data,
    .pred_pc, .pred_next, .pred_info,
    .trn_valid, .trn_correct, .trn_info, .trn_addr,
    .exe_fb_push, .exe_fb_epoch, .exe_fb_correct, .exe_fb_info, .exe_fb_addr, .exe_fb_full,
    .dec_fb_push, .dec_fb_eepoch, .dec_fb_depoch, .dec_fb_correct, .dec_fb_addr, .dec_fb_full,
    .fq_full, .fq_push, .fq_pc, .fq_inst, .fq_inum, .fq_eepoch, .fq_depoch, .fq_info, .fq_pred_next
  );

  typedef struct { logic [1:0] ep; logic ok; logic [31:0] info; logic [31:0] addr; } xent_t;
  typedef struct { logic [1:0] eep; logic [1:0] dep; logic ok; logic [31:0] addr; } dent_t;

  xent_t       xq[$];
  dent_t       dq[$];
  logic [31:0] m_pc = START;
  logic [1:0]  m_ee = '0, m_de = '0;
  logic [15:0] m_inum = '0;

  int  checks = 0, fails = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: compare at the current point, then advance the model for the next edge
  task automatic step_compare();
    bit    do_fetch, do_train, xhead_ok, dwin;
    string tag;
    logic [147:0] exp_b, act_b;
    xent_t xh;
    dent_t dh;
    do_fetch = 0; do_train = 0; dwin = 0;
    if (fq_full) tag = "R9";
    else if (xq.size() > 0) begin
      xh = xq[0];
      do_train = 1;
      xhead_ok = xh.ok;
      do_fetch = xhead_ok;
      tag = xhead_ok ? "R5" : "R4";
    end else if (dq.size() > 0) begin
      dh = dq[0];
      dwin = (dh.eep == m_ee) && !dh.ok;
      do_fetch = !dwin;
      tag = dwin ? "R7" : "R8";
    end else begin
      do_fetch = 1;
      tag = "R2";
    end

    chk(imem_req_valid == do_fetch && fq_push == do_fetch && imem_req_addr == m_pc, tag,
        "fetch valid/addr", {imem_req_valid, fq_push, imem_req_addr},
        {do_fetch, do_fetch, m_pc});
    if (do_fetch) begin
      exp_b = {m_pc, inst_of(m_pc), m_inum, m_ee, m_de, m_pc ^ IKEY, guess_of(m_pc)};
      act_b = {fq_pc, fq_inst, fq_inum, fq_eepoch, fq_depoch, fq_info, fq_pred_next};
      chk(act_b == exp_b, "R2", "bundle", act_b, exp_b);
    end
    chk(trn_valid == do_train, (xq.size() > 0 && dq.size() > 0) ? "R6" : "R3",
        "train valid", trn_valid, do_train);
    if (do_train)
      chk({trn_correct, trn_info, trn_addr} == {xh.ok, xh.info, xh.addr}, "R3", "train fields",
          {trn_correct, trn_info, trn_addr}, {xh.ok, xh.info, xh.addr});
    chk(exe_fb_full == (xq.size() == D) && dec_fb_full == (dq.size() == D), "R10", "queue full flags",
        {exe_fb_full, dec_fb_full}, {xq.size() == D, dq.size() == D});

    // model advance
    begin
      bit acc_x, acc_d;
      acc_x = exe_fb_push && (xq.size() < D);
      acc_d = dec_fb_push && (dq.size() < D);
      if (!fq_full) begin
        if (xq.size() > 0) begin
          void'(xq.pop_front());
          if (!xh.ok) begin m_pc = xh.addr; m_ee = xh.ep; end
        end else if (dq.size() > 0) begin
          void'(dq.pop_front());
          if (dwin) begin m_pc = dh.addr; m_de = dh.dep; end
        end
        if (do_fetch) begin m_pc = guess_of(m_pc); m_inum = m_inum + 16'd1; end
      end
      if (acc_x) xq.push_back('{exe_fb_epoch, exe_fb_correct, exe_fb_info, exe_fb_addr});
      if (acc_d) dq.push_back('{dec_fb_eepoch, dec_fb_depoch, dec_fb_correct, dec_fb_addr});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: state right after reset (fq_full held high, so the next edge stalls)
    chk(imem_req_addr == START && fq_inum == 16'd0 && fq_eepoch == 2'd0 && fq_depoch == 2'd0,
        "R1", "reset state", {imem_req_addr, fq_inum, fq_eepoch, fq_depoch}, {START, 16'd0, 2'd0, 2'd0});
    chk(!exe_fb_full && !dec_fb_full && !trn_valid && !imem_req_valid, "R1", "reset queues/outputs",
        {exe_fb_full, dec_fb_full, trn_valid, imem_req_valid}, 4'b0);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      int px, pd, pf, pstale;
      @(negedge clk);
      case (cyc / 500)
        0:       begin px = 0;  pd = 0;  pf = 5;  pstale = 0;  end
        1:       begin px = 30; pd = 0;  pf = 5;  pstale = 0;  end
        2:       begin px = 0;  pd = 35; pf = 5;  pstale = 10; end
        3:       begin px = 40; pd = 50; pf = 10; pstale = 40; end
        4:       begin px = 70; pd = 70; pf = 60; pstale = 30; end
        default: begin px = 25; pd = 25; pf = 20; pstale = 50; end
      endcase
      fq_full        = ($urandom_range(99) < pf);
      exe_fb_push    = ($urandom_range(99) < px);
      exe_fb_epoch   = 2'($urandom_range(3));
      exe_fb_correct = ($urandom_range(99) < 40);
      exe_fb_info    = $urandom;
      exe_fb_addr    = {$urandom_range(32'h3fff), 2'b00};
      dec_fb_push    = ($urandom_range(99) < pd);
      dec_fb_eepoch  = ($urandom_range(99) < pstale) ? m_ee + 2'd1 : m_ee;
      dec_fb_depoch  = 2'($urandom_range(3));
      dec_fb_correct = ($urandom_range(99) < 25);
      dec_fb_addr    = {$urandom_range(32'h3fff), 2'b00};
      #1;
      step_compare();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule